// File: doc/BRIEF.md
# Control Endpoint Mode and Status Register with Hardware Write Lock

This block is the mode and status byte for endpoint 0 of a USB device. It sits between the serial interface engine and the CPU register port. The engine sends one-cycle event pulses for each transaction:

- token decoded, together with its kind;
- data phase begins;
- handshake ACK sent;
- transaction finished.

The CPU reads and writes the byte. The byte holds three token flags, an ACK flag and a 4-bit response mode that firmware programs.

The engine writes fresh status at the end of each transaction. That update locks the lower seven bits against CPU writes until firmware reads the byte. The SETUP flag has stronger protection. Hardware holds it high from the start of the data phase of a SETUP transaction until the ACK goes out. After that it stays pinned until the CPU reads the byte. While the SETUP flag is high, the block raises an inhibit to the endpoint 0 data FIFO so firmware cannot overwrite the SETUP payload before reading it.

Top module: `ctlEpStatusReg`

## Requirements
- R1: After reset the byte reads 0x00, the FIFO inhibit is low, and the byte is unlocked.
- R2: The token kind is latched at the token pulse and encoded as 00 = SETUP, 01 = IN, 10 = OUT, 11 = none. At the end-of-transaction pulse, the flag for the latched kind is set. SETUP sets bit 7, IN sets bit 6, OUT sets bit 5, and kind 11 sets no flag. Flags already set are kept.
- R3: ACK flag (bit 4):
  - It is set at the end-of-transaction pulse if an ACK pulse arrived since the last token pulse.
  - If no ACK pulse arrived, it keeps its value.
- R4: When the byte is unlocked, a CPU write stores bits 6..0. Bits 3..0 are the mode field. A read returns the current byte, combinationally, in the cycle of the read strobe.
- R5: Every end-of-transaction pulse locks bits 6..0. While the byte is locked, CPU writes to those bits have no effect. A CPU write in the same cycle as the end-of-transaction pulse is also ignored for bits 6..0.
- R6: A CPU read removes the lock from the next cycle on. If a read and an end-of-transaction pulse fall in the same cycle, the byte stays locked.
- R7: A data-phase pulse while the latched kind is SETUP sets bit 7. Bit 7 stays high until the ACK pulse, and no CPU write can clear it in that window.
- R8: After the window, bit 7 stays pinned until the first CPU read that follows the window. A read inside the window does not release it.
- R9: The FIFO write inhibit output is high exactly when bit 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sieTokenDone | input | 1 | Token decoded pulse |
| sieTokenKind | input | 2 | Token kind (00 SETUP, 01 IN, 10 OUT, 11 none) |
| sieDataStart | input | 1 | Data phase start pulse |
| sieAckSent | input | 1 | ACK handshake pulse |
| sieXferEnd | input | 1 | End-of-transaction pulse |
| cpuWr | input | 1 | CPU write strobe |
| cpuWrData | input | 8 | CPU write data |
| cpuRd | input | 1 | CPU read strobe |
| cpuRdData | output | 8 | Current register byte |
| fifoWrBlock | output | 1 | Inhibit for CPU writes to the endpoint 0 FIFO |

## Verification
Each failure mode shows up at the ports within a known number of cycles:

- **Stale lock:** a write that should have been dropped changes the mode or flag bits. The next read shows it.
- **Lock lost early:** the same symptom, a write lands on bits that should be protected.
- **Window or pin flop wrong:** bit 7 and the FIFO inhibit fall one cycle after a write that should have been refused.
- **Latched token kind wrong:** the wrong flag appears at the first read after the end-of-transaction pulse.

The bench therefore reads back right after every protected write, and it checks the inhibit in the cycle after each SETUP event.

// File: rtl/ctlEpPkg.sv
package ctlEpPkg;
  localparam int ModeW    = 4;
  localparam int RegW     = ModeW + 4;
  localparam int AckBit   = ModeW;
  localparam int OutBit   = ModeW + 1;
  localparam int InBit    = ModeW + 2;
  localparam int SetupBit = ModeW + 3;

  typedef enum logic [1:0] {
    TokSetup = 2'd0,
    TokIn    = 2'd1,
    TokOut   = 2'd2,
    TokNone  = 2'd3
  } tokKindT;

  typedef struct packed {
    logic setSetupFlag;
    logic setInFlag;
    logic setOutFlag;
    logic setAckFlag;
    logic forceSetupNow;
    logic wrLow;
    logic wrTop;
  } ctlStrobeT;
endpackage

// File: rtl/ctlEpControl.sv
module ctlEpControl
  import ctlEpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sieTokenDone,
  input  logic [1:0] sieTokenKind,
  input  logic       sieDataStart,
  input  logic       sieAckSent,
  input  logic       sieXferEnd,
  input  logic       cpuWr,
  input  logic       cpuRd,
  output ctlStrobeT  strobe,
  output logic       windowOpen,
  output logic       setupPinned,
  output logic       locked
);
  tokKindT curKind;
  logic    ackSeen;
  logic    windowQ;
  logic    pinQ;
  logic    lockQ;
  logic    setupStart;

  assign setupStart = sieDataStart && (curKind == TokSetup);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curKind <= TokNone;
      ackSeen <= 1'b0;
      windowQ <= 1'b0;
      pinQ    <= 1'b0;
      lockQ   <= 1'b0;
    end else begin
      if (sieTokenDone) begin
        curKind <= tokKindT'(sieTokenKind);
        ackSeen <= 1'b0;
      end else if (sieAckSent) begin
        ackSeen <= 1'b1;
      end

      if (setupStart)      windowQ <= 1'b1;
      else if (sieAckSent) windowQ <= 1'b0;

      if (setupStart)               pinQ <= 1'b1;
      else if (cpuRd && !windowQ)   pinQ <= 1'b0;

      if (sieXferEnd) lockQ <= 1'b1;
      else if (cpuRd) lockQ <= 1'b0;
    end
  end

  always_comb begin
    strobe               = '0;
    strobe.setSetupFlag  = sieXferEnd && (curKind == TokSetup);
    strobe.setInFlag     = sieXferEnd && (curKind == TokIn);
    strobe.setOutFlag    = sieXferEnd && (curKind == TokOut);
    strobe.setAckFlag    = sieXferEnd && (ackSeen || sieAckSent);
    strobe.forceSetupNow = setupStart;
    strobe.wrLow         = cpuWr && !lockQ && !sieXferEnd;
    strobe.wrTop         = cpuWr && !windowQ && !pinQ && !setupStart;
  end

  assign windowOpen  = windowQ;
  assign setupPinned = pinQ;
  assign locked      = lockQ;

  // R5: an update always leaves the byte locked
  assert_update_locks_R5: assert property (@(posedge clk) disable iff (!rstN)
    sieXferEnd |=> lockQ);
  // R6: a lone read releases the lock
  assert_read_unlocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !sieXferEnd) |=> !lockQ);
  // R8: the pin cannot drop without a read
  assert_pin_needs_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinQ) |-> $past(cpuRd));
endmodule

// File: rtl/ctlEpDatapath.sv
module ctlEpDatapath
  import ctlEpPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobeT       strobe,
  input  logic [RegW-1:0] cpuWrData,
  output logic [RegW-1:0] regQ
);
  logic anyFlag;
  assign anyFlag = strobe.setSetupFlag | strobe.setInFlag | strobe.setOutFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ <= '0;
    end else begin
      if (strobe.wrLow) regQ[SetupBit-1:0] <= cpuWrData[SetupBit-1:0];
      if (strobe.wrTop) regQ[SetupBit]     <= cpuWrData[SetupBit];
      if (strobe.setInFlag)  regQ[InBit]  <= 1'b1;
      if (strobe.setOutFlag) regQ[OutBit] <= 1'b1;
      if (strobe.setAckFlag) regQ[AckBit] <= 1'b1;
      if (strobe.setSetupFlag || strobe.forceSetupNow) regQ[SetupBit] <= 1'b1;
    end
  end

  // R7: the start of a SETUP data phase raises bit 7
  assert_setup_forced_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceSetupNow |=> regQ[SetupBit]);
  // R2: one update adds at most one token flag
  assert_one_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    anyFlag |=> ($countones(regQ[SetupBit:OutBit] & ~$past(regQ[SetupBit:OutBit])) <= 1));
endmodule

// File: rtl/ctlEpStatusReg.sv
module ctlEpStatusReg
  import ctlEpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sieTokenDone,
  input  logic [1:0] sieTokenKind,
  input  logic       sieDataStart,
  input  logic       sieAckSent,
  input  logic       sieXferEnd,
  input  logic       cpuWr,
  input  logic [7:0] cpuWrData,
  input  logic       cpuRd,
  output logic [7:0] cpuRdData,
  output logic       fifoWrBlock
);
  ctlStrobeT       strobe;
  logic            windowOpen;
  logic            setupPinned;
  logic            locked;
  logic [RegW-1:0] regQ;

  ctlEpControl i_ctl (
    .clk(clk), .rstN(rstN),
    .sieTokenDone(sieTokenDone), .sieTokenKind(sieTokenKind),
    .sieDataStart(sieDataStart), .sieAckSent(sieAckSent), .sieXferEnd(sieXferEnd),
    .cpuWr(cpuWr), .cpuRd(cpuRd),
    .strobe(strobe), .windowOpen(windowOpen), .setupPinned(setupPinned), .locked(locked)
  );

  ctlEpDatapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuWrData(cpuWrData), .regQ(regQ)
  );

  assign cpuRdData   = regQ;
  assign fifoWrBlock = regQ[SetupBit];

  // R5: a write against a locked byte leaves bits 6..0 untouched
  assert_locked_write_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (locked && cpuWr && !sieXferEnd) |=> $stable(regQ[SetupBit-1:0]));
  // R9: the FIFO is blocked throughout the SETUP window
  assert_fifo_block_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    windowOpen |-> fifoWrBlock);
  // R8: the inhibit only falls after an unpinned CPU write of zero
  assert_setup_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fifoWrBlock) |-> ($past(cpuWr) && !$past(cpuWrData[SetupBit]) && !$past(setupPinned)));
endmodule

// File: tb/test_ctlEpStatusReg.sv
module test_ctlEpStatusReg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sieTokenDone = 1'b0;
  logic [1:0] sieTokenKind = 2'd3;
  logic       sieDataStart = 1'b0;
  logic       sieAckSent = 1'b0;
  logic       sieXferEnd = 1'b0;
  logic       cpuWr = 1'b0;
  logic [7:0] cpuWrData = 8'h00;
  logic       cpuRd = 1'b0;
  logic [7:0] cpuRdData;
  logic       fifoWrBlock;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } expItemT;
  expItemT expQ[$];

  always #2.5 clk = ~clk;

  ctlEpStatusReg i_ctlEpStatusReg (
    .clk(clk), .rstN(rstN),
    .sieTokenDone(sieTokenDone), .sieTokenKind(sieTokenKind),
    .sieDataStart(sieDataStart), .sieAckSent(sieAckSent), .sieXferEnd(sieXferEnd),
    .cpuWr(cpuWr), .cpuWrData(cpuWrData), .cpuRd(cpuRd),
    .cpuRdData(cpuRdData), .fifoWrBlock(fifoWrBlock)
  );

  // Monitor: pops an expected read value for every read strobe
  always @(negedge clk) begin
    if (cpuRd) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL read without expectation actual=%02h expected=none", cpuRdData);
      end else begin
        expItemT it;
        it = expQ.pop_front();
        if (cpuRdData !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, cpuRdData, it.exp);
        end
      end
    end
  end

  task automatic cycle();
    @(posedge clk); #1;
    sieTokenDone = 1'b0; sieDataStart = 1'b0; sieAckSent = 1'b0;
    sieXferEnd = 1'b0; cpuWr = 1'b0; cpuRd = 1'b0;
  endtask

  task automatic readExp(input logic [7:0] exp, input string tag);
    expItemT it;
    it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    cpuRd = 1'b1;
    cycle();
  endtask

  task automatic writeReg(input logic [7:0] d);
    cpuWr = 1'b1; cpuWrData = d;
    cycle();
  endtask

  task automatic token(input logic [1:0] k);
    sieTokenDone = 1'b1; sieTokenKind = k;
    cycle();
  endtask

  task automatic checkBlock(input logic exp, input string tag);
    checks++;
    if (fifoWrBlock !== exp) begin
      errors++;
      $display("FAIL %s fifoWrBlock actual=%0b expected=%0b", tag, fifoWrBlock, exp);
    end
  endtask

  task automatic fullTxn(input logic [1:0] k, input logic withAck);
    token(k);
    sieDataStart = 1'b1; cycle();
    if (withAck) begin sieAckSent = 1'b1; cycle(); end
    sieXferEnd = 1'b1; cycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    checkBlock(1'b0, "R1 reset inhibit");
    readExp(8'h00, "R1 reset value");
    writeReg(8'h05);
    readExp(8'h05, "R1 R4 unlocked after reset, mode write");

    // R2 R3 IN with ACK, then R5 locked write dropped
    fullTxn(2'd1, 1'b1);
    writeReg(8'h00);
    readExp(8'h55, "R5 write ignored while locked, R2 IN flag, R3 ack");
    writeReg(8'h03);
    readExp(8'h03, "R6 read released lock");

    // R2 OUT without ACK
    fullTxn(2'd2, 1'b0);
    readExp(8'h23, "R2 OUT flag, R3 no ack");
    writeReg(8'h00);
    readExp(8'h00, "R4 clear after unlock");

    // R7 R8 R9 SETUP sequence
    token(2'd0);
    checkBlock(1'b0, "R9 inhibit low before data phase");
    sieDataStart = 1'b1; cycle();
    checkBlock(1'b1, "R7 R9 inhibit high at data phase");
    readExp(8'h80, "R7 SETUP flag forced");
    writeReg(8'h00);
    readExp(8'h80, "R7 write in window cannot clear");
    sieAckSent = 1'b1; cycle();
    writeReg(8'h07);
    readExp(8'h87, "R8 pinned after window, low bits written");
    checkBlock(1'b1, "R9 inhibit while pinned");
    writeReg(8'h01);
    readExp(8'h01, "R8 released by read after window");
    checkBlock(1'b0, "R9 inhibit drops with bit 7");

    // R8 pinned across the update until a read
    token(2'd0);
    sieDataStart = 1'b1; cycle();
    sieAckSent = 1'b1; cycle();
    writeReg(8'h00);
    sieXferEnd = 1'b1; cycle();
    writeReg(8'h00);
    readExp(8'h90, "R8 R2 R3 SETUP update, pinned and locked");
    writeReg(8'h00);
    readExp(8'h00, "R8 R6 clear after read");

    // R6 same-cycle read and update
    token(2'd2);
    sieAckSent = 1'b1; cycle();
    sieXferEnd = 1'b1;
    readExp(8'h00, "R6 read sees pre-update value");
    writeReg(8'h0F);
    readExp(8'h30, "R6 update wins over read, still locked");
    writeReg(8'h0F);
    readExp(8'h0F, "R6 unlocked after later read");

    // R2 kind none: no flag but locks; R5 write in update cycle dropped
    token(2'd3);
    sieXferEnd = 1'b1; cpuWr = 1'b1; cpuWrData = 8'h02; cycle();
    writeReg(8'h00);
    readExp(8'h0F, "R2 R5 kind none sets no flag, locks");

    cycle();
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", expQ.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule